// File: doc/BRIEF.md
# Prime-Table Driven Pair Scheduler

This block sequences the pair loop of the second stage of elliptic-curve factoring. The host loads two bit tables, a starting outer index and an outer iteration count, then pulses a start input. For each outer index m, counted upward from the loaded minimum, the scheduler sweeps the odd residues j from 1 to D/2. It presents a pair (m, j) to the downstream product accumulator only when two tests hold: j is coprime to D, and the prime-pair bit stored for (m, j) is set. Every presented pair carries the compact position k of j among the coprime residues, so the stored multiple jQ0 can be addressed directly.

When a sweep over j ends, a one-cycle advance strobe tells the point arithmetic to step R to R + Q. After the strobe for the final outer index, a one-cycle done pulse follows. Point arithmetic and the final GCD are outside the block.

States: ST_IDLE waits for start. ST_FETCH reads the prime row for the current m. ST_SCAN tests one odd slot per cycle. ST_OFFER holds a pair until it is accepted. ST_ADV emits the advance strobe. ST_DONE emits the done pulse. Transitions:
- IDLE→FETCH on start with a non-zero count.
- IDLE→DONE on start with a zero count.
- FETCH→SCAN always.
- SCAN→OFFER on a hit.
- SCAN→ADV on a miss in the last slot.
- OFFER→SCAN or OFFER→ADV on acceptance.
- ADV→FETCH when outer indices remain.
- ADV→DONE after the last one.
- DONE→IDLE always.

Top module: `psched_top`

## Requirements
- R1: Only odd j = 2s+1 (slot s = 0 .. D/4 rounded, j ≤ D/2) are visited. The coprime table holds one bit per odd slot s. A slot whose bit is 0 is never presented. Every presented pair_j is odd and at most D/2.
- R2: A coprime slot is presented only when bit k of the prime row for its outer index is 1. Here k (pair_k) is the number of coprime slots below it. The number of presented pairs equals the number of such hits.
- R3: Pairs come out in ascending m, starting at the m_min captured at start. Within one m they come out in ascending j, and pair_m = m_min + row.
- R4: While pair_valid is high and pair_ready is low, pair_valid stays high and pair_m, pair_j and pair_k hold steady. A pair is taken on a cycle where both are high.
- R5: After the last slot of each outer index, adv_pt is high for exactly one cycle, and only then. A run yields exactly m_count strobes.
- R6: done is high for exactly one cycle, in the cycle right after the final adv_pt. With m_count = 0, done appears in the cycle after start, with no pair and no strobe.
- R7: start, m_min and m_count are ignored while a run is in progress. Those values are captured only in the idle state.
- R8: Both tables keep their contents across runs. A second run without reloading produces pairs from the same tables.
- R9: Under reset, pair_valid, adv_pt and done are all low.
- R10: cop_wr_en writes cop_wr_bit to slot cop_wr_slot. pt_wr_en stores pt_wr_bits as the row for outer offset pt_wr_row, where bit k belongs to compact index k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cop_wr_en | input | 1 | Coprime table write strobe |
| cop_wr_slot | input | SW (6) | Odd slot index, j = 2*slot+1 |
| cop_wr_bit | input | 1 | Coprime bit value |
| pt_wr_en | input | 1 | Prime row write strobe |
| pt_wr_row | input | RW (9) | Outer offset m - m_min |
| pt_wr_bits | input | KW (24) | Prime bits, bit k for compact index k |
| start | input | 1 | Begin a run (taken only when idle) |
| m_min | input | MMW (16) | First outer index |
| m_count | input | RW+1 (10) | Number of outer indices |
| pair_valid | output | 1 | Pair presented |
| pair_ready | input | 1 | Accumulator accepts the pair |
| pair_m | output | MMW (16) | Outer index of the pair |
| pair_j | output | JW (7) | Odd residue j |
| pair_k | output | KIW (5) | Compact index of j among coprime slots |
| adv_pt | output | 1 | One-cycle strobe: step R to R + Q |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The assertions assume the following about the inputs:
- The coprime table holds no more ones than the prime row is wide.
- Tables are written only while the block is idle.
- m_count does not exceed the row capacity.

The stimulus keeps to these rules. It loads the coprime table from a true gcd test against D, or with a bit cleared, which only lowers the count. All table writes are finished before start, and m_count stays small. pair_ready is held high in some runs and throttled periodically in others, so the hold property is exercised while stalls occur.

// File: rtl/psched_pkg.sv
package psched_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SCAN,
        ST_OFFER,
        ST_ADV,
        ST_DONE
    } psched_state_e;

    function automatic int gcd_f(input int a, input int b);
        int x;
        int y;
        int t;
        x = a;
        y = b;
        while (y != 0) begin
            t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    // number of odd residues 1,3,.. not above d/2
    function automatic int odd_slots(input int d);
        return (d / 2 + 1) / 2;
    endfunction

    // number of odd residues not above d/2 that are coprime to d
    function automatic int coprime_slots(input int d);
        int c;
        c = 0;
        for (int j = 1; j <= d / 2; j += 2) begin
            if (gcd_f(j, d) == 1) c++;
        end
        return c;
    endfunction

endpackage

// File: rtl/psched_cop_table.sv
module psched_cop_table #(
    parameter int NJ = 53,
    parameter int SW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_slot,
    input  logic          wr_bit,
    output logic [NJ-1:0] bits
);
    generate
        for (genvar s = 0; s < NJ; s++) begin : g_slot
            localparam logic [SW-1:0] SLOT = SW'(s);
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bits[s] <= 1'b0;
                end else if (wr_en && wr_slot == SLOT) begin
                    bits[s] <= wr_bit;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/psched_prime_ram.sv
module psched_prime_ram #(
    parameter int ROWS = 512,
    parameter int RW   = 9,
    parameter int KW   = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_row,
    input  logic [KW-1:0] wr_bits,
    input  logic          rd_en,
    input  logic [RW-1:0] rd_row,
    output logic [KW-1:0] rd_bits
);
    logic [KW-1:0] mem [ROWS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_row] <= wr_bits;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_bits <= '0;
        end else if (rd_en) begin
            rd_bits <= mem[rd_row];
        end
    end
endmodule

// File: rtl/psched_top.sv
module psched_top
    import psched_pkg::*;
#(
    parameter int D      = 210,
    parameter int MN_MAX = 512,
    parameter int MMW    = 16,
    localparam int NJ    = odd_slots(D),
    localparam int KW    = coprime_slots(D),
    localparam int SW    = $clog2(NJ),
    localparam int RW    = $clog2(MN_MAX),
    localparam int KIW   = $clog2(KW + 1),
    localparam int JW    = $clog2(D / 2 + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cop_wr_en,
    input  logic [SW-1:0]  cop_wr_slot,
    input  logic           cop_wr_bit,
    input  logic           pt_wr_en,
    input  logic [RW-1:0]  pt_wr_row,
    input  logic [KW-1:0]  pt_wr_bits,
    input  logic           start,
    input  logic [MMW-1:0] m_min,
    input  logic [RW:0]    m_count,
    output logic           pair_valid,
    input  logic           pair_ready,
    output logic [MMW-1:0] pair_m,
    output logic [JW-1:0]  pair_j,
    output logic [KIW-1:0] pair_k,
    output logic           adv_pt,
    output logic           done
);
    localparam logic [SW-1:0]  LAST_SLOT = SW'(NJ - 1);
    localparam logic [KIW-1:0] KW_L      = KIW'(KW);

    psched_state_e state, nstate;

    logic [NJ-1:0]  cop_vec;
    logic [KW-1:0]  prime_row;
    logic [MMW-1:0] m_base_q;
    logic [RW:0]    m_cnt_q;
    logic [RW:0]    row_q;
    logic [SW-1:0]  slot_q;
    logic [KIW-1:0] kcnt_q;
    logic [MMW-1:0] pm_q;
    logic [JW-1:0]  pj_q;
    logic [KIW-1:0] pk_q;

    logic cop_bit, prime_bit, hit, last_slot, last_row;

    psched_cop_table #(.NJ(NJ), .SW(SW)) u_cop (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cop_wr_en),
        .wr_slot (cop_wr_slot),
        .wr_bit  (cop_wr_bit),
        .bits    (cop_vec)
    );

    psched_prime_ram #(.ROWS(MN_MAX), .RW(RW), .KW(KW)) u_prime (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pt_wr_en),
        .wr_row  (pt_wr_row),
        .wr_bits (pt_wr_bits),
        .rd_en   (state == ST_FETCH),
        .rd_row  (row_q[RW-1:0]),
        .rd_bits (prime_row)
    );

    // slot tests
    always_comb begin
        cop_bit   = cop_vec[slot_q];
        prime_bit = (kcnt_q < KW_L) ? prime_row[kcnt_q] : 1'b0;
        hit       = cop_bit && prime_bit;
        last_slot = (slot_q == LAST_SLOT);
        last_row  = (row_q == m_cnt_q - 1'b1);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nstate;
        end
    end

    // transitions
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: begin
                if (start) nstate = (m_count == '0) ? ST_DONE : ST_FETCH;
            end
            ST_FETCH: nstate = ST_SCAN;
            ST_SCAN: begin
                if (hit)            nstate = ST_OFFER;
                else if (last_slot) nstate = ST_ADV;
            end
            ST_OFFER: begin
                if (pair_ready) nstate = last_slot ? ST_ADV : ST_SCAN;
            end
            ST_ADV:  nstate = last_row ? ST_DONE : ST_FETCH;
            ST_DONE: nstate = ST_IDLE;
            default: nstate = ST_IDLE;
        endcase
    end

    // counters and pair registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_base_q <= '0;
            m_cnt_q  <= '0;
            row_q    <= '0;
            slot_q   <= '0;
            kcnt_q   <= '0;
            pm_q     <= '0;
            pj_q     <= '0;
            pk_q     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        m_base_q <= m_min;
                        m_cnt_q  <= m_count;
                        row_q    <= '0;
                    end
                end
                ST_FETCH: begin
                    slot_q <= '0;
                    kcnt_q <= '0;
                end
                ST_SCAN: begin
                    if (hit) begin
                        pm_q <= m_base_q + MMW'(row_q);
                        pj_q <= JW'({slot_q, 1'b1});
                        pk_q <= kcnt_q;
                    end else begin
                        kcnt_q <= kcnt_q + KIW'(cop_bit);
                        if (!last_slot) slot_q <= slot_q + 1'b1;
                    end
                end
                ST_OFFER: begin
                    if (pair_ready) begin
                        kcnt_q <= kcnt_q + 1'b1;
                        if (!last_slot) slot_q <= slot_q + 1'b1;
                    end
                end
                ST_ADV:  row_q <= row_q + 1'b1;
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        pair_valid = (state == ST_OFFER);
        adv_pt     = (state == ST_ADV);
        done       = (state == ST_DONE);
        pair_m     = pm_q;
        pair_j     = pj_q;
        pair_k     = pk_q;
    end

endmodule

// File: rtl/psched_checks.sv
module psched_checks
    import psched_pkg::*;
#(
    parameter int D      = 210,
    localparam int KW    = coprime_slots(D),
    localparam int KIW   = $clog2(KW + 1),
    localparam int JW    = $clog2(D / 2 + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           pair_valid,
    input logic           pair_ready,
    input logic [JW-1:0]  pair_j,
    input logic [KIW-1:0] pair_k,
    input logic           adv_pt,
    input logic           done
);
    localparam logic [JW-1:0]  J_TOP = JW'(D / 2);
    localparam logic [KIW-1:0] K_TOP = KIW'(KW);

    AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid && !pair_ready) |=> (pair_valid && $stable(pair_j) && $stable(pair_k))); // R4
    AST_J_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> (pair_j[0] && pair_j <= J_TOP)); // R1
    AST_K_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> (pair_k < K_TOP)); // R2
    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pair_valid, adv_pt, done})); // R5
    AST_ADV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        adv_pt |=> !adv_pt); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(adv_pt) || $past(start))); // R6

endmodule

bind psched_top psched_checks #(.D(D)) u_psched_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .pair_valid (pair_valid),
    .pair_ready (pair_ready),
    .pair_j     (pair_j),
    .pair_k     (pair_k),
    .adv_pt     (adv_pt),
    .done       (done)
);

// File: tb/psched_top_test.sv
`timescale 1ns/1ps
module psched_top_test;
    localparam int D   = 210;
    localparam int NJ  = (D / 2 + 1) / 2;
    localparam int SW  = 6;
    localparam int RW  = 9;
    localparam int KIW = 5;
    localparam int JW  = 7;
    localparam int MMW = 16;

    function automatic int tb_gcd(input int a, input int b);
        int x;
        int y;
        int t;
        x = a;
        y = b;
        while (y != 0) begin
            t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    function automatic int tb_kw(input int d);
        int c;
        c = 0;
        for (int j = 1; j <= d / 2; j += 2) if (tb_gcd(j, d) == 1) c++;
        return c;
    endfunction

    localparam int KW = tb_kw(D);

    logic           clk = 1'b0;
    logic           rst_n;
    logic           cop_wr_en;
    logic [SW-1:0]  cop_wr_slot;
    logic           cop_wr_bit;
    logic           pt_wr_en;
    logic [RW-1:0]  pt_wr_row;
    logic [KW-1:0]  pt_wr_bits;
    logic           start;
    logic [MMW-1:0] m_min;
    logic [RW:0]    m_count;
    logic           pair_valid;
    logic           pair_ready;
    logic [MMW-1:0] pair_m;
    logic [JW-1:0]  pair_j;
    logic [KIW-1:0] pair_k;
    logic           adv_pt;
    logic           done;

    always #10 clk = ~clk;

    psched_top uut (
        .clk(clk), .rst_n(rst_n),
        .cop_wr_en(cop_wr_en), .cop_wr_slot(cop_wr_slot), .cop_wr_bit(cop_wr_bit),
        .pt_wr_en(pt_wr_en), .pt_wr_row(pt_wr_row), .pt_wr_bits(pt_wr_bits),
        .start(start), .m_min(m_min), .m_count(m_count),
        .pair_valid(pair_valid), .pair_ready(pair_ready),
        .pair_m(pair_m), .pair_j(pair_j), .pair_k(pair_k),
        .adv_pt(adv_pt), .done(done)
    );

    int n_total = 0;
    int n_fail  = 0;
    bit tb_cop [NJ];
    int cur_seed;

    // vector table: m_min, m_count, prime seed, throttle ready, reload prime rows
    localparam int NV = 5;
    localparam int V_MMIN [NV] = '{5, 100, 40, 7, 300};
    localparam int V_MN   [NV] = '{3, 4, 4, 6, 2};
    localparam int V_SEED [NV] = '{0, 1, 1, 3, 5};
    localparam int V_STALL[NV] = '{0, 1, 0, 1, 1};
    localparam int V_LOAD [NV] = '{1, 1, 0, 1, 1};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit pbit(input int seed, input int r, input int k);
        if (seed == 4) return 1'b0;
        if (seed == 5) return 1'b1;
        return ((r * 5 + k * 3 + seed) % 4) == 0;
    endfunction

    function automatic int kidx(input int s);
        int c;
        c = 0;
        for (int t = 0; t < s; t++) if (tb_cop[t]) c++;
        return c;
    endfunction

    function automatic int find_next(input int seed, input int r, input int s0);
        for (int s = s0; s < NJ; s++) begin
            if (tb_cop[s] && pbit(seed, r, kidx(s))) return s;
        end
        return NJ;
    endfunction

    task automatic write_cop(input int s, input bit b);
        @(negedge clk);
        cop_wr_en = 1'b1; cop_wr_slot = SW'(s); cop_wr_bit = b;
        @(negedge clk);
        cop_wr_en = 1'b0;
        tb_cop[s] = b;
    endtask

    // R10: bit k of a row word belongs to compact index k
    task automatic load_prime(input int seed, input int mn);
        for (int r = 0; r < mn; r++) begin
            @(negedge clk);
            pt_wr_en = 1'b1;
            pt_wr_row = RW'(r);
            for (int k = 0; k < KW; k++) pt_wr_bits[k] = pbit(seed, r, k);
        end
        @(negedge clk);
        pt_wr_en = 1'b0;
        cur_seed = seed;
    endtask

    task automatic run(input int mmin, input int mn, input int stall, input int extra, input string tag);
        int er, es, cyc, advs, pairs, exp_pairs, nx;
        bit fin, prev_last;
        exp_pairs = 0;
        for (int r = 0; r < mn; r++) begin
            int s;
            s = find_next(cur_seed, r, 0);
            while (s < NJ) begin
                exp_pairs++;
                s = find_next(cur_seed, r, s + 1);
            end
        end
        @(negedge clk);
        m_min = MMW'(mmin); m_count = (RW + 1)'(mn); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        er = 0; es = 0; cyc = 0; advs = 0; pairs = 0; fin = 0; prev_last = 0;
        while (!fin && cyc < 20000) begin
            if (extra != 0 && cyc == 5) begin
                start = 1'b1; m_min = MMW'(mmin + 50); m_count = (RW + 1)'(mn + 1);
            end else begin
                start = 1'b0;
            end
            pair_ready = (stall != 0) ? ((cyc % 3) != 1) : 1'b1;
            if (prev_last) check(done == 1'b1, "R6 done after final strobe", int'(done), 1);
            if (mn == 0 && cyc == 0) check(done == 1'b1, "R6 empty run", int'(done), 1);
            if (done) begin
                check(er == mn, {tag, " R6 done row"}, er, mn);
                fin = 1;
            end
            if (pair_valid) begin
                nx = find_next(cur_seed, er, es);
                check(nx < NJ, {tag, " R2 pair expected"}, nx, NJ - 1);
                check(int'(pair_m) == mmin + er, {tag, " R3 pair_m"}, int'(pair_m), mmin + er);
                check(int'(pair_j) == 2 * nx + 1, {tag, " R1 pair_j"}, int'(pair_j), 2 * nx + 1);
                check(int'(pair_k) == kidx(nx), {tag, " R2 pair_k"}, int'(pair_k), kidx(nx));
                if (pair_ready) begin
                    pairs++;
                    es = nx + 1;
                end
            end
            prev_last = 0;
            if (adv_pt) begin
                nx = find_next(cur_seed, er, es);
                check(nx == NJ, {tag, " R5 strobe after sweep"}, nx, NJ);
                er++; es = 0; advs++;
                prev_last = (er == mn);
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check(fin, {tag, " R6 run finished"}, int'(fin), 1);
        check(advs == mn, {tag, " R5 strobe count"}, advs, mn);
        check(pairs == exp_pairs, {tag, " R2 pair count"}, pairs, exp_pairs);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cop_wr_en = 1'b0; cop_wr_slot = '0; cop_wr_bit = 1'b0;
        pt_wr_en = 1'b0; pt_wr_row = '0; pt_wr_bits = '0;
        start = 1'b0; m_min = '0; m_count = '0; pair_ready = 1'b0;
        cur_seed = 0;
        for (int s = 0; s < NJ; s++) tb_cop[s] = 1'b0;
        repeat (3) @(negedge clk);
        // R9: reset state
        check({pair_valid, adv_pt, done} == 3'b000, "R9 reset outputs", int'({pair_valid, adv_pt, done}), 0);
        rst_n = 1'b1;

        // R10: coprime table from gcd against D
        for (int s = 0; s < NJ; s++) write_cop(s, tb_gcd(2 * s + 1, D) == 1);

        // vector loop; R8: vector 2 reuses rows of vector 1 without reload
        for (int v = 0; v < NV; v++) begin
            if (V_LOAD[v] != 0) load_prime(V_SEED[v], V_MN[v]);
            run(V_MMIN[v], V_MN[v], V_STALL[v], 0, $sformatf("vec%0d", v));
        end

        // R6: empty run
        run(9, 0, 0, 0, "empty");

        // all-zero prime rows: only strobes (R5)
        load_prime(4, 3);
        run(11, 3, 0, 0, "noprime");

        // R7: start and new operands during a run are ignored
        load_prime(0, 3);
        run(20, 3, 1, 1, "restart");

        // R10 / R1: clear slot of j=1 and rerun with all-ones rows
        write_cop(0, 1'b0);
        load_prime(5, 2);
        run(60, 2, 0, 0, "copclr");

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule